// File: doc/BRIEF.md
# Mailbox Address Decoder and Bus-Switch Controller

This block sits in one node of a mesh of multi-processor modules. Each node has several processors that share one time-multiplexed private bus to local memory. It also has interconnection buses to its four neighbours. The block looks at the address that the processor in the current phase puts out and decides where that access goes. The access either stays in local memory, lands in the node's own mailbox, or goes to the mailbox of a neighbour. In the last case the block raises a request on the chosen interconnection bus.

When this node acknowledges a neighbour, the block places that neighbour's address on the local memory. Clearing one address bit is enough to do this, so no translation table is needed. The block also computes the enables and the direction for the tristate switches from the serviced-request, acknowledge and read/write lines. The switches are the processor-select switches, the private-bus switch, and the address and data groups of each interconnection-bus switch. A software-writable isolation register can switch off any processor or any neighbour. The drivers themselves, the handshake arbitration and the clock generation live outside this block.

Top module: `mbx_switch_top`

## Requirements
- R1: The address is decoded as tag = bits [15:13], external flag = bit 12, bus number = bits [11:10] and offset = bits [9:0]. `local_mb` is 1 when `cpu_valid` is 1, the tag equals `MBOX_TAG` (default 5) and the external flag is 0. `loc_sel` is 1 when `cpu_valid` is 1 and the access is not an external mailbox access (tag equal to `MBOX_TAG` with the external flag 1).
- R2: `mb_req[c]` is 1 only when `cpu_valid` is 1, the tag matches, the external flag is 1, the bus field equals c and neighbour c is not isolated. At most one bit is ever set.
- R3: `ack_out[k]` acknowledges a neighbour whose request carried bus number k; that neighbour is attached to local bus 3-k (bitwise inverse). If any effective `ack_out` is set, the lowest such k selects the address on `ib_addr_in` bus 3-k. `mem_addr` is that address with bit 12 forced to 0, and `remote_active` is 1. Otherwise `mem_addr` equals `cpu_addr` and `remote_active` is 0.
- R4: `ps_en[i]` is 1 only when `phase[i]` is 1, no effective `ack_out` is set and processor i is not isolated.
- R5: `pbs_en` is 1 unless an effective `svc_req` or an effective `ack_in` is set on any bus.
- R6: `ibs_a_en[c]` is (effective `svc_req[c]` AND effective `ack_in[c]`) OR effective `ack_out[3-c]`.
- R7: `ibs_d_en[c]` equals `ibs_a_en[c]`. `ibs_d_out[c]` (1 = drive from this node onto the bus) is 1 on an outgoing write (request path with `rd_wr`=0) or on an incoming read (acknowledge path with `ib_rd_in[c]`=1).
- R8: The isolation register resets to 0. When `iso_we` is 1 it loads `iso_wdata` on the next clock edge, and `iso_q` shows the stored value. Bits [2:0] isolate processors 0..2; bits [6:3] isolate neighbours on buses 0..3.
- R9: Isolating neighbour c masks `svc_req[c]`, `ack_in[c]`, `ack_out[3-c]` and `mb_req[c]` in every output. Isolating processor i forces `ps_en[i]` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_we | input | 1 | Isolation register write strobe |
| iso_wdata | input | 7 | Isolation register write value |
| iso_q | output | 7 | Isolation register contents |
| cpu_valid | input | 1 | Processor address is valid this cycle |
| cpu_addr | input | 16 | Address from the processor in the active phase |
| rd_wr | input | 1 | Local processor direction, 1 = read |
| phase | input | 3 | One-hot interlaced processor phase |
| svc_req | input | 4 | Serviced request per bus, from the arbiter |
| ack_in | input | 4 | Acknowledge received per bus |
| ack_out | input | 4 | Acknowledge sent, indexed by requester bus number |
| ib_addr_in | input | 64 | Incoming address per bus, bus b at [16b+15:16b] |
| ib_rd_in | input | 4 | Incoming direction per bus, 1 = read |
| local_mb | output | 1 | Access hits own mailbox |
| loc_sel | output | 1 | Access is served by local memory |
| mb_req | output | 4 | Mailbox request toward each neighbour |
| mem_addr | output | 16 | Address presented to local memory |
| remote_active | output | 1 | A neighbour owns local memory |
| ps_en | output | 3 | Processor-select switch enables |
| pbs_en | output | 1 | Private-bus switch enable |
| ibs_a_en | output | 4 | Interconnection address-group enables |
| ibs_d_en | output | 4 | Interconnection data-group enables |
| ibs_d_out | output | 4 | Interconnection data direction, 1 = outward |

## Verification
The bench builds the block with its default parameters: a 16-bit address, four buses and three processors. With those values there are only 4096 combinations of serviced-request, acknowledge-in and acknowledge-out. Every one of them is swept against sixteen isolation masks, including all-clear and all-set, while the address, phase and direction fields vary with the vector index. A separate pass walks all 64 combinations of tag, external flag and bus number. That small width puts the whole masking and mirroring logic, and the full address decode, within reach of an exhaustive comparison.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic {
      DIR_INWARD  = 1'b0,
      DIR_OUTWARD = 1'b1
   } drive_dir_e;

   // Bus on this node that faces a neighbour which used bus number k.
   function automatic int unsigned mirror_bus(input int unsigned k, input int unsigned nbus);
      return nbus - 1 - k;
   endfunction

endpackage

// File: rtl/mbx_iso_reg.sv
module mbx_iso_reg #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned OFFS_W   = 10,
   parameter int unsigned BUS_W    = 2,
   parameter int unsigned MBOX_TAG = 5,
   localparam int unsigned NBUS    = 1 << BUS_W
) (
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [NBUS-1:0]   nbr_iso,
   output logic              local_mb,
   output logic              loc_sel,
   output logic [NBUS-1:0]   mb_req
);

   localparam int unsigned EXT_POS = OFFS_W + BUS_W;
   localparam int unsigned TAG_W   = ADDR_W - EXT_POS - 1;

   logic [TAG_W-1:0] tag_f;
   logic             ext_f;
   logic [BUS_W-1:0] bus_f;
   logic             tag_hit;

   assign tag_f   = cpu_addr[ADDR_W-1 -: TAG_W];
   assign ext_f   = cpu_addr[EXT_POS];
   assign bus_f   = cpu_addr[OFFS_W +: BUS_W];
   assign tag_hit = cpu_valid && (tag_f == TAG_W'(MBOX_TAG));

   assign local_mb = tag_hit && !ext_f;
   assign loc_sel  = cpu_valid && !(tag_hit && ext_f);

   for (genvar c = 0; c < NBUS; c++) begin : g_req
      assign mb_req[c] = tag_hit && ext_f && (bus_f == BUS_W'(c)) && !nbr_iso[c];
   end

endmodule

// File: rtl/mbx_remap.sv
module mbx_remap #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned OFFS_W    = 10,
   parameter int unsigned BUS_W     = 2,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned NBUS     = 1 << BUS_W
) (
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic [NBUS-1:0]        aout_m,
   input  logic [NBUS*ADDR_W-1:0] ib_addr_in,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   remote_active
);

   localparam int unsigned EXT_POS = OFFS_W + BUS_W;

   logic [BUS_W-1:0]  sel_k;
   logic [BUS_W-1:0]  sel_bus;
   logic [ADDR_W-1:0] in_word;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         sel_k = '0;
         for (int k = NBUS - 1; k >= 0; k--) begin
            if (aout_m[k]) sel_k = BUS_W'(k);
         end
      end
   end else begin : g_high
      always_comb begin
         sel_k = '0;
         for (int k = 0; k < NBUS; k++) begin
            if (aout_m[k]) sel_k = BUS_W'(k);
         end
      end
   end

   assign sel_bus       = ~sel_k;
   assign in_word       = ib_addr_in[int'(sel_bus)*ADDR_W +: ADDR_W];
   assign remote_active = |aout_m;

   always_comb begin
      if (remote_active) begin
         mem_addr          = in_word;
         mem_addr[EXT_POS] = 1'b0;
      end else begin
         mem_addr = cpu_addr;
      end
   end

endmodule

// File: rtl/mbx_switch_ctl.sv
module mbx_switch_ctl
   import mbx_pkg::*;
#(
   parameter int unsigned NPROC = 3,
   parameter int unsigned BUS_W = 2,
   localparam int unsigned NBUS = 1 << BUS_W
) (
   input  logic [NPROC-1:0] phase,
   input  logic [NPROC-1:0] proc_iso,
   input  logic [NBUS-1:0]  svc_m,
   input  logic [NBUS-1:0]  ain_m,
   input  logic [NBUS-1:0]  aout_m,
   input  logic             rd_wr,
   input  logic [NBUS-1:0]  ib_rd_in,
   output logic [NPROC-1:0] ps_en,
   output logic             pbs_en,
   output logic [NBUS-1:0]  ibs_a_en,
   output logic [NBUS-1:0]  ibs_d_en,
   output logic [NBUS-1:0]  ibs_d_out
);

   logic any_ack_out;
   assign any_ack_out = |aout_m;
   assign pbs_en      = !((|svc_m) || (|ain_m));

   for (genvar i = 0; i < NPROC; i++) begin : g_ps
      assign ps_en[i] = phase[i] && !any_ack_out && !proc_iso[i];
   end

   for (genvar c = 0; c < NBUS; c++) begin : g_ibs
      localparam int unsigned MC = mirror_bus(c, NBUS);
      logic       out_path;
      logic       in_path;
      drive_dir_e dir;

      assign out_path = svc_m[c] && ain_m[c];
      assign in_path  = aout_m[MC];

      always_comb begin
         if ((out_path && !rd_wr) || (in_path && ib_rd_in[c])) dir = DIR_OUTWARD;
         else                                                  dir = DIR_INWARD;
      end

      assign ibs_a_en[c]  = out_path || in_path;
      assign ibs_d_en[c]  = out_path || in_path;
      assign ibs_d_out[c] = (dir == DIR_OUTWARD);
   end

endmodule

// File: rtl/mbx_switch_top.sv
module mbx_switch_top
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned OFFS_W    = 10,
   parameter int unsigned BUS_W     = 2,
   parameter int unsigned NPROC     = 3,
   parameter int unsigned MBOX_TAG  = 5,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned NBUS     = 1 << BUS_W,
   localparam int unsigned ISO_W    = NPROC + NBUS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iso_we,
   input  logic [ISO_W-1:0]       iso_wdata,
   output logic [ISO_W-1:0]       iso_q,
   input  logic                   cpu_valid,
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic                   rd_wr,
   input  logic [NPROC-1:0]       phase,
   input  logic [NBUS-1:0]        svc_req,
   input  logic [NBUS-1:0]        ack_in,
   input  logic [NBUS-1:0]        ack_out,
   input  logic [NBUS*ADDR_W-1:0] ib_addr_in,
   input  logic [NBUS-1:0]        ib_rd_in,
   output logic                   local_mb,
   output logic                   loc_sel,
   output logic [NBUS-1:0]        mb_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   remote_active,
   output logic [NPROC-1:0]       ps_en,
   output logic                   pbs_en,
   output logic [NBUS-1:0]        ibs_a_en,
   output logic [NBUS-1:0]        ibs_d_en,
   output logic [NBUS-1:0]        ibs_d_out
);

   localparam int unsigned TAG_W = ADDR_W - OFFS_W - BUS_W - 1;

   if (TAG_W < 1) begin : g_bad_split
      $error("address too narrow for tag, flag, bus and offset fields");
   end
   if (MBOX_TAG >= (1 << TAG_W)) begin : g_bad_tag
      $error("MBOX_TAG does not fit in the tag field");
   end
   if (NPROC < 1) begin : g_bad_proc
      $error("at least one processor is required");
   end

   logic [NBUS-1:0]  nbr_iso;
   logic [NPROC-1:0] proc_iso;
   logic [NBUS-1:0]  svc_m;
   logic [NBUS-1:0]  ain_m;
   logic [NBUS-1:0]  aout_m;

   mbx_iso_reg #(.WIDTH(ISO_W)) u_iso (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (iso_we),
      .wdata (iso_wdata),
      .q     (iso_q)
   );

   assign proc_iso = iso_q[NPROC-1:0];
   assign nbr_iso  = iso_q[ISO_W-1:NPROC];

   for (genvar c = 0; c < NBUS; c++) begin : g_mask
      localparam int unsigned MC = mirror_bus(c, NBUS);
      assign svc_m[c]  = svc_req[c] && !nbr_iso[c];
      assign ain_m[c]  = ack_in[c]  && !nbr_iso[c];
      assign aout_m[c] = ack_out[c] && !nbr_iso[MC];
   end

   mbx_addr_decode #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BUS_W(BUS_W), .MBOX_TAG(MBOX_TAG)
   ) u_dec (
      .cpu_valid (cpu_valid),
      .cpu_addr  (cpu_addr),
      .nbr_iso   (nbr_iso),
      .local_mb  (local_mb),
      .loc_sel   (loc_sel),
      .mb_req    (mb_req)
   );

   mbx_remap #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BUS_W(BUS_W), .LOW_FIRST(LOW_FIRST)
   ) u_remap (
      .cpu_addr      (cpu_addr),
      .aout_m        (aout_m),
      .ib_addr_in    (ib_addr_in),
      .mem_addr      (mem_addr),
      .remote_active (remote_active)
   );

   mbx_switch_ctl #(.NPROC(NPROC), .BUS_W(BUS_W)) u_sw (
      .phase     (phase),
      .proc_iso  (proc_iso),
      .svc_m     (svc_m),
      .ain_m     (ain_m),
      .aout_m    (aout_m),
      .rd_wr     (rd_wr),
      .ib_rd_in  (ib_rd_in),
      .ps_en     (ps_en),
      .pbs_en    (pbs_en),
      .ibs_a_en  (ibs_a_en),
      .ibs_d_en  (ibs_d_en),
      .ibs_d_out (ibs_d_out)
   );

endmodule

// File: rtl/mbx_switch_chk.sv
module mbx_switch_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFFS_W = 10,
   parameter int unsigned BUS_W  = 2,
   parameter int unsigned NPROC  = 3,
   localparam int unsigned NBUS  = 1 << BUS_W,
   localparam int unsigned ISO_W = NPROC + NBUS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iso_we,
   input logic [ISO_W-1:0]  iso_wdata,
   input logic [ISO_W-1:0]  iso_q,
   input logic              cpu_valid,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [NPROC-1:0]  phase,
   input logic [NBUS-1:0]   svc_req,
   input logic [NBUS-1:0]   ack_out,
   input logic [NBUS-1:0]   mb_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [NPROC-1:0]  ps_en,
   input logic              pbs_en,
   input logic [NBUS-1:0]   ibs_a_en
);

   localparam int unsigned EXT_POS = OFFS_W + BUS_W;

   logic [NBUS-1:0] nbr_iso;
   logic [NBUS-1:0] nbr_iso_mirror;
   assign nbr_iso = iso_q[ISO_W-1:NPROC];
   for (genvar k = 0; k < NBUS; k++) begin : g_mir
      assign nbr_iso_mirror[k] = nbr_iso[NBUS-1-k];
   end

   assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mb_req));

   assert_req_needs_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|mb_req) |-> (cpu_valid && cpu_addr[EXT_POS]));

   assert_remap_clears_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_out & ~nbr_iso_mirror)) |-> !mem_addr[EXT_POS]);

   assert_ps_in_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en & ~phase) == '0);

   assert_pbs_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(svc_req & ~nbr_iso)) |-> !pbs_en);

   assert_iso_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iso_we |=> (iso_q == $past(iso_wdata)));

   assert_iso_proc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en & iso_q[NPROC-1:0]) == '0);

   assert_iso_nbr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ibs_a_en | mb_req) & nbr_iso) == '0);

endmodule

bind mbx_switch_top mbx_switch_chk #(
   .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BUS_W(BUS_W), .NPROC(NPROC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iso_we    (iso_we),
   .iso_wdata (iso_wdata),
   .iso_q     (iso_q),
   .cpu_valid (cpu_valid),
   .cpu_addr  (cpu_addr),
   .phase     (phase),
   .svc_req   (svc_req),
   .ack_out   (ack_out),
   .mb_req    (mb_req),
   .mem_addr  (mem_addr),
   .ps_en     (ps_en),
   .pbs_en    (pbs_en),
   .ibs_a_en  (ibs_a_en)
);

// File: tb/sim_mbx_switch_top.sv
module sim_mbx_switch_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iso_we = 1'b0;
   logic [6:0]  iso_wdata = '0;
   logic [6:0]  iso_q;
   logic        cpu_valid = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        rd_wr = 1'b0;
   logic [2:0]  phase = '0;
   logic [3:0]  svc_req = '0;
   logic [3:0]  ack_in = '0;
   logic [3:0]  ack_out = '0;
   logic [63:0] ib_addr_in = '0;
   logic [3:0]  ib_rd_in = '0;
   logic        local_mb, loc_sel, remote_active, pbs_en;
   logic [3:0]  mb_req, ibs_a_en, ibs_d_en, ibs_d_out;
   logic [15:0] mem_addr;
   logic [2:0]  ps_en;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   mbx_switch_top u0 (
      .clk(clk), .rst_n(rst_n), .iso_we(iso_we), .iso_wdata(iso_wdata), .iso_q(iso_q),
      .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .rd_wr(rd_wr), .phase(phase),
      .svc_req(svc_req), .ack_in(ack_in), .ack_out(ack_out), .ib_addr_in(ib_addr_in),
      .ib_rd_in(ib_rd_in), .local_mb(local_mb), .loc_sel(loc_sel), .mb_req(mb_req),
      .mem_addr(mem_addr), .remote_active(remote_active), .ps_en(ps_en), .pbs_en(pbs_en),
      .ibs_a_en(ibs_a_en), .ibs_d_en(ibs_d_en), .ibs_d_out(ibs_d_out)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Independent model of every output, from the requirement text.
   task automatic check_all();
      logic [2:0] tag = cpu_addr[15:13];
      logic       ext = cpu_addr[12];
      logic [1:0] bus = cpu_addr[11:10];
      logic       hit = cpu_valid && (tag == 3'd5);
      logic [3:0] ni  = iso_q[6:3];
      logic [2:0] pi  = iso_q[2:0];
      logic [3:0] sm, am, om, e_req, e_a, e_do;
      logic [2:0] e_ps;
      logic [15:0] e_mem = cpu_addr;
      logic        e_rem = 1'b0;
      for (int c = 0; c < 4; c++) begin
         sm[c] = svc_req[c] && !ni[c];
         am[c] = ack_in[c] && !ni[c];
         om[c] = ack_out[c] && !ni[3-c];
         e_req[c] = hit && ext && (int'(bus) == c) && !ni[c];
      end
      for (int k = 3; k >= 0; k--) begin
         if (om[k]) begin
            e_rem = 1'b1;
            e_mem = ib_addr_in[(3-k)*16 +: 16] & 16'hEFFF;
         end
      end
      for (int i = 0; i < 3; i++) e_ps[i] = phase[i] && (om == 4'd0) && !pi[i];
      for (int c = 0; c < 4; c++) begin
         e_a[c]  = (sm[c] && am[c]) || om[3-c];
         e_do[c] = (sm[c] && am[c] && !rd_wr) || (om[3-c] && ib_rd_in[c]);
      end
      chk("R1", "local_mb", 32'(local_mb), 32'(hit && !ext));
      chk("R1", "loc_sel", 32'(loc_sel), 32'(cpu_valid && !(hit && ext)));
      chk("R2", "mb_req", 32'(mb_req), 32'(e_req));
      chk("R3", "mem_addr", 32'(mem_addr), 32'(e_mem));
      chk("R3", "remote_active", 32'(remote_active), 32'(e_rem));
      chk("R4", "ps_en", 32'(ps_en), 32'(e_ps));
      chk("R5", "pbs_en", 32'(pbs_en), 32'((sm == 4'd0) && (am == 4'd0)));
      chk("R6", "ibs_a_en", 32'(ibs_a_en), 32'(e_a));
      chk("R7", "ibs_d_en", 32'(ibs_d_en), 32'(e_a));
      chk("R7", "ibs_d_out", 32'(ibs_d_out), 32'(e_do));
   endtask

   task automatic write_iso(input logic [6:0] v);
      @(posedge clk); #1;
      iso_we = 1'b1; iso_wdata = v;
      @(posedge clk); #1;
      iso_we = 1'b0; iso_wdata = ~v;
      #1 chk("R8", "iso_q after write", 32'(iso_q), 32'(v));
      @(posedge clk); #1;
      chk("R8", "iso_q held with we low", 32'(iso_q), 32'(v));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1 chk("R8", "iso_q in reset", 32'(iso_q), 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R8", "iso_q after reset", 32'(iso_q), 32'd0);
      chk("R5", "pbs_en idle", 32'(pbs_en), 32'd1);
      check_all();

      // R1 R2: every tag/ext/bus combination, valid and not valid
      for (int t = 0; t < 64; t++) begin
         for (int v = 0; v < 2; v++) begin
            @(posedge clk); #1;
            cpu_valid = v[0];
            cpu_addr  = {t[5:0], 10'(t * 37 + 3)};
            #1 check_all();
         end
      end

      // R3..R9: all request/acknowledge patterns under several isolation masks
      for (int m = 0; m < 16; m++) begin
         logic [6:0] iso_v;
         iso_v = (m == 0) ? 7'h00 : (m == 15) ? 7'h7F : 7'((m * 37) & 127);
         write_iso(iso_v);
         for (int v = 0; v < 4096; v++) begin
            logic [11:0] b;
            b = 12'(v);
            @(posedge clk); #1;
            svc_req   = b[3:0];
            ack_in    = b[7:4];
            ack_out   = b[11:8];
            cpu_valid = (v % 7) != 0;
            cpu_addr  = {(b[2:0] == 3'd7) ? 3'd2 : 3'd5, b[5] ^ b[9], b[7:6] ^ b[1:0], 10'(v * 13)};
            phase     = (v % 4 == 3) ? 3'd0 : 3'(1 << (v % 4));
            rd_wr     = b[10] ^ b[3];
            ib_rd_in  = b[3:0] ^ b[11:8];
            for (int bb = 0; bb < 4; bb++)
               ib_addr_in[bb*16 +: 16] = (16'hF000 ^ 16'(bb * 16'h0421) ^ 16'(v)) | 16'h1000;
            #1 check_all();
         end
      end

      write_iso(7'h00);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule